// File: doc/BRIEF.md
# Instruction-Fetch Address Patch Trap

This block sits beside a processor's instruction-fetch bus and compares every valid fetch address against a bank of programmable trap addresses. Each trap entry has its own enable bit. When a valid fetch hits an enabled entry, the block raises a bus-fault pulse. An exception handler then sends execution to a patched copy of the code. The block also stores the number of the entry that fired in a sticky status word, and this word stays set until software clears it.

Software programs the block through a single-cycle 32-bit register port, using byte offsets. Read data is combinational and follows the offset in the same cycle. Writes take effect at the next clock edge.

The register layout is:
- The trap addresses fill consecutive words from offset 0x00.
- The enable mask follows the last entry.
- The status word comes next.
- A write-only clear register sits at 0xA8.

Top module: `fetch_patch_trap`

## Requirements
- R1: After reset, every trap address reads 0, the enable mask reads 0, the status reads 0 and `busFault` is low.
- R2: Trap entry n (0..29) is a full 32-bit read/write word at byte offset 4*n, so entry 29 is at 0x74.
- R3: The enable mask is at 0x78. Only bits [29:0] are stored, bit n enables entry n, and bits [31:30] read as 0.
- R4: `busFault` is high for exactly the one cycle after a cycle in which `fetchValid` is high and `fetchAddr` equals all 32 bits of an enabled entry. It stays low when `fetchValid` is low, when the matching entry is disabled, or when the address differs.
- R5: The status word is at 0x7C. Bit 0 is the error flag and bits [5:1] hold the entry index. Both are updated at the same clock edge that raises `busFault`.
- R6: When several enabled entries match one fetch, the lowest-numbered entry's index is recorded.
- R7: While the error flag is set, a new match still pulses `busFault` but leaves the recorded index unchanged.
- R8: Writing a word with bit 0 = 1 to offset 0xA8 clears the error flag and the index, and writing 0 there has no effect. If the clear and a match happen in the same cycle, the flag stays set and the new index is recorded.
- R9: Offsets that map to nothing, and unaligned offsets, read as 0 and ignore writes. Writes to the status word and reads of the clear register have no effect and return 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch address strobe |
| fetchAddr | input | 32 | Instruction-fetch address |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| busFault | output | 1 | One-cycle fault pulse after a trapped fetch |

## Verification
A wrong comparator or enable bit shows up one cycle after the offending fetch: `busFault` either appears or fails to appear. A faulty priority encoder or a faulty sticky-update rule is seen only in the status word. A read of 0x7C right after each fault therefore exposes a wrong index or flag within two cycles of the fetch. A broken register decode appears immediately on the readback of the entry, the enable mask, or an unmapped offset.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // Width of the word part of the register offset (byte offset is WORD_W+2 bits).
  localparam int WORD_W = 6;

  typedef struct packed {
    logic              entryWr;
    logic              enWr;
    logic              clrFlag;
    logic [WORD_W-1:0] entrySel;
  } trapStrobe_t;
endpackage

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int NUM_TRAPS = 30,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = $clog2(NUM_TRAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trapStrobe_t          strobes,
  input  logic [ADDR_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    fetchAddr,
  output logic                 anyHit,
  output logic [IDX_W-1:0]     hitIdx,
  output logic [ADDR_W-1:0]    entryRdData,
  output logic [NUM_TRAPS-1:0] enableVal
);
  logic [ADDR_W-1:0]    trapAddr [NUM_TRAPS];
  logic [NUM_TRAPS-1:0] enableReg;
  logic [NUM_TRAPS-1:0] matchVec;

  for (genvar g = 0; g < NUM_TRAPS; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        trapAddr[g] <= '0;
      else if (strobes.entryWr && strobes.entrySel == WORD_W'(g))
        trapAddr[g] <= wrData;
    end
    assign matchVec[g] = enableReg[g] && (trapAddr[g] == fetchAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      enableReg <= '0;
    else if (strobes.enWr)
      enableReg <= wrData[NUM_TRAPS-1:0];
  end

  // The descending scan lets the lowest matching entry win.
  always_comb begin
    anyHit = |matchVec;
    hitIdx = '0;
    for (int i = NUM_TRAPS - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  always_comb begin
    entryRdData = '0;
    for (int i = 0; i < NUM_TRAPS; i++)
      if (strobes.entrySel == WORD_W'(i)) entryRdData = trapAddr[i];
  end

  assign enableVal = enableReg;

  AST_HIT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> ((matchVec & ((NUM_TRAPS'(1) << hitIdx) - NUM_TRAPS'(1))) == '0)); // R6

  AST_HIT_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (enableReg[hitIdx] && trapAddr[hitIdx] == fetchAddr)); // R4
endmodule

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
#(
  parameter int          NUM_TRAPS = 30,
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = $clog2(NUM_TRAPS),
  parameter int unsigned CLR_OFF   = 32'hA8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [WORD_W+1:0]    regAddr,
  input  logic                 wrBit0,
  input  logic                 fetchValid,
  input  logic                 anyHit,
  input  logic [IDX_W-1:0]     hitIdx,
  input  logic [ADDR_W-1:0]    entryRdData,
  input  logic [NUM_TRAPS-1:0] enableVal,
  output trapStrobe_t          strobes,
  output logic [ADDR_W-1:0]    regRdData,
  output logic                 busFault
);
  localparam logic [WORD_W-1:0] EN_WORD  = WORD_W'(NUM_TRAPS);
  localparam logic [WORD_W-1:0] STS_WORD = WORD_W'(NUM_TRAPS + 1);
  localparam logic [WORD_W-1:0] CLR_WORD = WORD_W'(CLR_OFF >> 2);

  logic [WORD_W-1:0] wordIdx;
  logic              aligned, isEntry, isEn, isSts, isClr;
  logic              hitNow;
  logic              errFlag;
  logic [IDX_W-1:0]  errIdx;

  assign wordIdx = regAddr[WORD_W+1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign isEntry = aligned && (wordIdx < EN_WORD);
  assign isEn    = aligned && (wordIdx == EN_WORD);
  assign isSts   = aligned && (wordIdx == STS_WORD);
  assign isClr   = aligned && (wordIdx == CLR_WORD);

  always_comb begin
    strobes.entryWr  = regWrEn && isEntry;
    strobes.enWr     = regWrEn && isEn;
    strobes.clrFlag  = regWrEn && isClr && wrBit0;
    strobes.entrySel = wordIdx;
  end

  assign hitNow = fetchValid && anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busFault <= 1'b0;
      errFlag  <= 1'b0;
      errIdx   <= '0;
    end else begin
      busFault <= hitNow;
      if (hitNow && (!errFlag || strobes.clrFlag)) begin
        errFlag <= 1'b1;
        errIdx  <= hitIdx;
      end else if (strobes.clrFlag) begin
        errFlag <= 1'b0;
        errIdx  <= '0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (isEntry)    regRdData = entryRdData;
    else if (isEn)  regRdData = ADDR_W'(enableVal);
    else if (isSts) regRdData = ADDR_W'({errIdx, errFlag});
  end

  AST_FAULT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    busFault |-> $past(fetchValid)); // R4

  AST_FLAG_WITH_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    busFault |-> errFlag); // R5

  AST_STICKY_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strobes.clrFlag) |=> (errFlag && $stable(errIdx))); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag && !hitNow) |=> !errFlag); // R8

  AST_CLEAR_AND_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag && hitNow) |=> (errFlag && errIdx == $past(hitIdx))); // R8

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && isSts && !hitNow) |=> ($stable(errFlag) && $stable(errIdx))); // R9
endmodule

// File: rtl/fetch_patch_trap.sv
module fetch_patch_trap
  import trap_pkg::*;
#(
  parameter int          NUM_TRAPS = 30,
  parameter int          ADDR_W    = 32,
  parameter int unsigned CLR_OFF   = 32'hA8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              regWrEn,
  input  logic [WORD_W+1:0] regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              busFault
);
  localparam int IDX_W = $clog2(NUM_TRAPS);

  trapStrobe_t          strobes;
  logic                 anyHit;
  logic [IDX_W-1:0]     hitIdx;
  logic [ADDR_W-1:0]    entryRdData;
  logic [NUM_TRAPS-1:0] enableVal;

  trap_datapath #(.NUM_TRAPS(NUM_TRAPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .fetchAddr(fetchAddr), .anyHit(anyHit), .hitIdx(hitIdx),
    .entryRdData(entryRdData), .enableVal(enableVal)
  );

  trap_control #(.NUM_TRAPS(NUM_TRAPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
                 .CLR_OFF(CLR_OFF)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrBit0(regWrData[0]), .fetchValid(fetchValid), .anyHit(anyHit),
    .hitIdx(hitIdx), .entryRdData(entryRdData), .enableVal(enableVal),
    .strobes(strobes), .regRdData(regRdData), .busFault(busFault)
  );
endmodule

// File: tb/tb_fetch_patch_trap.sv
`timescale 1ns/1ps
module tb_fetch_patch_trap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busFault;
  logic        rdStrobe = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  fetch_patch_trap dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .busFault(busFault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one register read, expectation goes to the scoreboard.
  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = addr; rdStrobe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] addr, input logic valid, input logic expFault,
                       input string tag);
    @(negedge clk);
    fetchValid = valid; fetchAddr = addr;
    @(negedge clk);
    fetchValid = 1'b0;
    #1 check(busFault == expFault, tag, 32'(busFault), 32'(expFault));
    @(negedge clk);
    #1 check(busFault == 1'b0, "R4 pulse lasts one cycle", 32'(busFault), 32'h0);
  endtask

  task automatic clrAndFetch(input logic [31:0] addr);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'hA8; regWrData = 32'h1;
    fetchValid = 1'b1; fetchAddr = addr;
    @(negedge clk);
    regWrEn = 1'b0; fetchValid = 1'b0;
    #1 check(busFault == 1'b1, "R8 fault on clear+match cycle", 32'(busFault), 32'h1);
  endtask

  // Monitor: pops the scoreboard whenever a read is on the port.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rdStrobe) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(regRdData === e, t, regRdData, e);
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 check(busFault == 1'b0, "R1 fault low after reset", 32'(busFault), 32'h0);
    rd(8'h00, 32'h0, "R1 entry 0 reset");
    rd(8'h74, 32'h0, "R1 entry 29 reset");
    rd(8'h78, 32'h0, "R1 enable reset");
    rd(8'h7C, 32'h0, "R1 status reset");

    wr(8'h00, 32'h1000_0000);
    wr(8'h14, 32'hDEAD_BEE0);
    wr(8'h1C, 32'hDEAD_BEE0);
    wr(8'h74, 32'hFFFF_FFFC);
    rd(8'h00, 32'h1000_0000, "R2 entry 0 readback");
    rd(8'h14, 32'hDEAD_BEE0, "R2 entry 5 readback");
    rd(8'h74, 32'hFFFF_FFFC, "R2 entry 29 readback");

    wr(8'h78, 32'hFFFF_FFFF);
    rd(8'h78, 32'h3FFF_FFFF, "R3 upper enable bits read 0");
    wr(8'h78, 32'h0);
    fetch(32'hDEAD_BEE0, 1'b1, 1'b0, "R4 disabled entry no fault");

    wr(8'h78, 32'h0000_0080);
    fetch(32'hDEAD_BEE1, 1'b1, 1'b0, "R4 one-bit mismatch no fault");
    fetch(32'hDEAD_BEE0, 1'b0, 1'b0, "R4 fetchValid low no fault");
    rd(8'h7C, 32'h0, "R4 status untouched without fault");
    fetch(32'hDEAD_BEE0, 1'b1, 1'b1, "R4 enabled match faults");
    rd(8'h7C, 32'h0000_000F, "R5 status flag and index 7");

    wr(8'hA8, 32'h0);
    rd(8'h7C, 32'h0000_000F, "R8 writing 0 to clear has no effect");
    wr(8'hA8, 32'h1);
    rd(8'h7C, 32'h0, "R8 clear empties status");

    wr(8'h78, 32'h2000_00A0);
    fetch(32'hDEAD_BEE0, 1'b1, 1'b1, "R6 multi-match faults");
    rd(8'h7C, 32'h0000_000B, "R6 lowest index 5 recorded");

    fetch(32'hFFFF_FFFC, 1'b1, 1'b1, "R7 sticky flag still faults");
    rd(8'h7C, 32'h0000_000B, "R7 index held while flag set");

    clrAndFetch(32'hFFFF_FFFC);
    rd(8'h7C, 32'h0000_003B, "R8 clear+match records index 29");

    wr(8'h7C, 32'h0);
    rd(8'h7C, 32'h0000_003B, "R9 status write ignored");
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, 32'h0, "R9 unmapped offset reads 0");
    rd(8'hA8, 32'h0, "R9 clear register reads 0");
    wr(8'h01, 32'h1234_5678);
    rd(8'h00, 32'h1000_0000, "R9 unaligned write ignored");
    rd(8'h01, 32'h0, "R9 unaligned read 0");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule